// File: doc/BRIEF.md
# Spare-Node Configuration Enumerator

This block steers a linear processing array built from N working positions plus K spare nodes, N+K nodes in all. At any moment it picks K nodes to leave out. The remaining N nodes, in ascending index order, form the active chain. The block drives one enable for every link that could ever be used in such a chain, and the pass gates in the array follow these enables.

A link runs from node a forward to node a+d, with d from 1 to K+1. External port i can be tied to node i through node i+K. When a watchdog outside this block decides the array has stalled, it raises a time-out level. Each rising edge of that level moves the block to the next choice of survivors. The search cycles through every choice for ever. A choice that failed because of a transient fault is therefore tried again on a later lap.

Top module: `spare_cfg_enum`

## Requirements
- R1: After synchronous reset the survivors are nodes 0 to N-1. External port i is enabled to node i. Internal links a->a+1 are enabled for a from 0 to N-2, and no other bit is high.
- R2: A rising edge of `timeout_i` seen at a clock edge moves the block to the next survivor set. The outputs show the new set from that same clock edge.
- R3: While `timeout_i` stays high, or stays low, the outputs do not change. A level held high for several cycles advances the set only once.
- R4: Survivor sets are listed as ascending index lists and visited in lexicographic order. With N=4 and N+K=6 the order begins 0123, 0124, 0125, 0134.
- R5: After the last set, where nodes K to N+K-1 survive, the next rising edge returns to the reset set. A full lap is C(N+K,K) advances.
- R6: External enable bit i*(K+1)+d is high exactly when the i-th survivor (counting from 0) is node i+d, for d in 0..K.
- R7: Internal enable bit a*(K+1)+(d-1) is high exactly when nodes a and a+d are consecutive survivors. Bits whose target would be past node N+K-1 are always low.
- R8: In every state exactly N external enables and exactly N-1 internal enables are high.
- R9: Within one lap no survivor set repeats. Each set's survivor list is strictly ascending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_i | input | 1 | Stall time-out level; each rising edge advances the search |
| ext_en_o | output | N*(K+1) | External port link enables, bit i*(K+1)+d ties port i to node i+d |
| int_en_o | output | (N+K)*(K+1) | Internal link enables, bit a*(K+1)+(d-1) enables link a->a+d |

## Verification
The hardest state to reach from the ports is the wrap from the last survivor set back to the first. It needs a full lap of C(N+K,K) rising edges. Each edge along the way must land on exactly the right set, or the wrap is never seen at the right point. The bench walks a table of all fifteen default survivor lists and checks both enable vectors after every pulse. It then applies one more pulse to catch the wrap, holds the time-out high to confirm only one step is taken, and resets in mid-lap.

// File: rtl/spare_cfg_pkg.sv
package spare_cfg_pkg;

  // binomial coefficient used to size the search lap
  function automatic int unsigned binom(input int unsigned n, input int unsigned k);
    longint unsigned acc;
    acc = 1;
    for (int unsigned i = 1; i <= k; i++) begin
      acc = acc * (n - k + i) / i;
    end
    return int'(acc);
  endfunction

endpackage

// File: rtl/spare_rise_det.sv
module spare_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/spare_succ.sv
// Lexicographic successor of an ascending N-of-T survivor list, with wrap.
module spare_succ #(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int IW = 3
) (
  input  logic [N-1:0][IW-1:0] cur_i,
  output logic [N-1:0][IW-1:0] nxt_o
);
  localparam int T = N + K;

  logic found;
  int   piv;

  always_comb begin
    found = 1'b0;
    piv   = 0;
    for (int j = N - 1; j >= 0; j--) begin
      if (!found && (cur_i[j] != IW'(T - N + j))) begin
        found = 1'b1;
        piv   = j;
      end
    end
    for (int j = 0; j < N; j++) begin
      if (!found)
        nxt_o[j] = IW'(j);
      else if (j < piv)
        nxt_o[j] = cur_i[j];
      else
        nxt_o[j] = IW'(int'(cur_i[piv]) + 1 + j - piv);
    end
  end
endmodule

// File: rtl/spare_decode.sv
// Turns a survivor list into external and internal link enables.
module spare_decode #(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int IW = 3
) (
  input  logic [N-1:0][IW-1:0]       sel_i,
  output logic [N*(K+1)-1:0]         ext_o,
  output logic [(N+K)*(K+1)-1:0]     int_o
);
  localparam int T  = N + K;
  localparam int FO = K + 1;

  always_comb begin
    ext_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int d = 0; d < FO; d++) begin
        if (sel_i[i] == IW'(i + d)) ext_o[i*FO + d] = 1'b1;
      end
    end
  end

  always_comb begin
    int_o = '0;
    for (int a = 0; a < T; a++) begin
      for (int d = 1; d <= FO; d++) begin
        if (a + d < T) begin
          for (int j = 0; j < N - 1; j++) begin
            if (sel_i[j] == IW'(a) && sel_i[j+1] == IW'(a + d))
              int_o[a*FO + d - 1] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spare_cfg_enum.sv
module spare_cfg_enum #(
  parameter int N = 4,
  parameter int K = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      timeout_i,
  output logic [N*(K+1)-1:0]        ext_en_o,
  output logic [(N+K)*(K+1)-1:0]    int_en_o
);
  import spare_cfg_pkg::*;

  localparam int T       = N + K;
  localparam int FO      = K + 1;
  localparam int IW      = $clog2(T + 1);
  localparam int NUM_CFG = binom(T, K);

  logic                  adv;
  logic [N-1:0][IW-1:0]  sel_q, sel_d, sel_nxt, sel_init;
  logic [N*FO-1:0]       ext_d;
  logic [T*FO-1:0]       int_d;

  spare_rise_det u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (timeout_i),
    .rise_o (adv)
  );

  spare_succ #(.N(N), .K(K), .IW(IW)) u_succ (
    .cur_i (sel_q),
    .nxt_o (sel_nxt)
  );

  always_comb begin
    for (int j = 0; j < N; j++) sel_init[j] = IW'(j);
    if (rst)      sel_d = sel_init;
    else if (adv) sel_d = sel_nxt;
    else          sel_d = sel_q;
  end

  spare_decode #(.N(N), .K(K), .IW(IW)) u_dec (
    .sel_i (sel_d),
    .ext_o (ext_d),
    .int_o (int_d)
  );

  always_ff @(posedge clk) begin
    sel_q    <= sel_d;
    ext_en_o <= ext_d;
    int_en_o <= int_d;
  end

  AST_EXT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(ext_en_o) == N); // R8
  AST_INT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(int_en_o) == N - 1); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(ext_en_o) && $stable(int_en_o))); // R3
  AST_LAST_NODE: assert property (@(posedge clk) disable iff (rst)
    sel_q[N-1] < IW'(T)); // R9

  generate
    if (NUM_CFG > 1) begin : g_adv_chk
      AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        adv |=> (ext_en_o != $past(ext_en_o))); // R2
    end
    for (genvar j = 0; j + 1 < N; j++) begin : g_order_chk
      AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        sel_q[j] < sel_q[j+1]); // R9
    end
  endgenerate
endmodule

// File: tb/spare_cfg_enum_tb.sv
module spare_cfg_enum_tb;
  localparam int N  = 4;
  localparam int K  = 2;
  localparam int FO = K + 1;
  localparam int T  = N + K;
  localparam int NV = 15;

  // survivor lists, one hex digit per survivor, lexicographic order (R4)
  localparam logic [15:0] SURV [NV] = '{
    16'h0123, 16'h0124, 16'h0125, 16'h0134, 16'h0135,
    16'h0145, 16'h0234, 16'h0235, 16'h0245, 16'h0345,
    16'h1234, 16'h1235, 16'h1245, 16'h1345, 16'h2345 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic timeout_i = 1'b0;
  logic [N*FO-1:0] ext_en_o;
  logic [T*FO-1:0] int_en_o;
  int   applied = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spare_cfg_enum #(.N(N), .K(K)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .timeout_i (timeout_i),
    .ext_en_o  (ext_en_o),
    .int_en_o  (int_en_o)
  );

  function automatic int node_of(logic [15:0] s, int j);
    return int'(s[15 - 4*j -: 4]);
  endfunction

  function automatic logic [N*FO-1:0] exp_ext(logic [15:0] s);
    logic [N*FO-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i*FO + node_of(s, i) - i] = 1'b1;
    return v;
  endfunction

  function automatic logic [T*FO-1:0] exp_int(logic [15:0] s);
    logic [T*FO-1:0] v = '0;
    for (int j = 0; j < N - 1; j++)
      v[node_of(s, j)*FO + node_of(s, j+1) - node_of(s, j) - 1] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] s);
    applied++;
    if (ext_en_o !== exp_ext(s) || int_en_o !== exp_int(s)) begin
      bad++;
      $display("FAIL %s set %h: ext act %b exp %b, int act %b exp %b",
               tag, s, ext_en_o, exp_ext(s), int_en_o, exp_int(s));
    end
  endtask

  task automatic pulse();
    @(negedge clk) timeout_i = 1'b1;
    @(negedge clk) timeout_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", SURV[0]);
    // walk the whole lap: R2 R4 R6 R7 R8 R9
    for (int v = 1; v < NV; v++) begin
      pulse();
      check("R2/R4/R6/R7/R8/R9 step", SURV[v]);
    end
    // wrap back to the first set: R5
    pulse();
    check("R5 wrap", SURV[0]);
    // long high level advances once only: R3
    @(negedge clk) timeout_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 held high", SURV[1]);
    timeout_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 held low", SURV[1]);
    // reset in mid-lap: R1
    pulse(); pulse();
    check("R4 mid", SURV[3]);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 reset mid-lap", SURV[0]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule